// File: doc/BRIEF.md
# Single-Channel Word DMA Engine

This block is one bus-master DMA channel that moves a run of 32-bit words between a device-side word stream and host memory. Software programs three registers: a word-aligned bus address, a word count and a control/status register. It then sets the start bit. The channel issues one request per word on a valid/ready memory interface and advances the address by four bytes after each accepted word. When the count runs out, it drops the start bit, sends a one-cycle done pulse and, if enabled, raises an interrupt.

In the device-to-memory direction, each request is a write whose data comes from the device FIFO, and the FIFO is popped when the word is accepted. In the memory-to-device direction, each request is a read, and the returned word is passed to the device on a one-cycle output strobe. An error response from memory aborts the transfer, latches the error flag and always raises the interrupt. Software acknowledges the interrupt by writing the control register with the start bit clear.

Top module: `dma_word_channel`

## Requirements
- R1: After reset the channel is idle: no memory request, no FIFO pop, irq and done low, and all three registers read back as zero.
- R2: Register select 0 is the bus address; its two low bits are forced to zero on write. It reads back the current address, which rises by 4 for each accepted word.
- R3: Register select 1 is the word count. Only bits 20:0 are stored and upper written bits are ignored. It reads back the words still to move.
- R4: Register select 2 is control/status: bit 0 error, bit 1 interrupt enable, bit 2 start (reads 1 while busy), bit 3 direction with 1 meaning device to memory. With direction 1, word i is written to address base+4*i with the FIFO word, and the FIFO is popped exactly on acceptance.
- R5: In device-to-memory mode a request is made only while the FIFO has data. A request held by ready low keeps its address and data stable.
- R6: When the last word is accepted, the busy/start bit clears and donePulse is high for exactly the next cycle. irq rises in that same cycle if bit 1 is set.
- R7: With bit 1 clear, a completed transfer still pulses done but leaves irq low.
- R8: Starting with a word count of zero completes at once: done (and irq if enabled) rise the cycle after the write, and no memory request is made.
- R9: A memory error response on an accepted word aborts the transfer without a done pulse. It sets the error bit and raises irq even when bit 1 is clear, and the erroring word does not advance the count.
- R10: Any write to the control register clears irq; writing 1 to bit 0 clears the error flag. The acknowledge value 0x0B therefore clears both and starts nothing.
- R11: While a transfer is active, writes to the address, count and control registers do not restart or alter it.
- R12: With direction 0 the requests are reads (memReqWrite low). Each returned word appears on devOutData with devOutValid for the accepting cycle, and the FIFO is never popped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 address, 1 count, 2 control/status |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data of the selected register |
| fifoValid | input | 1 | Device FIFO holds a word |
| fifoData | input | 32 | Device FIFO head word |
| fifoPop | output | 1 | Pops the FIFO head |
| devOutValid | output | 1 | Word read from memory is valid for the device |
| devOutData | output | 32 | Word read from memory |
| memReqValid | output | 1 | Memory request valid |
| memReqWrite | output | 1 | Request is a write (1) or a read (0) |
| memReqAddr | output | 32 | Word-aligned byte address |
| memReqData | output | 32 | Write data |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memRespErr | input | 1 | Error response, qualified by acceptance |
| memRdata | input | 32 | Read data, qualified by acceptance |
| irq | output | 1 | Latched interrupt |
| donePulse | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The checker covers the properties that hold on every cycle. A stalled request keeps its address, and no request is made while idle. FIFO pops occur only with an accepted write and never in read mode. Addresses are always aligned, the done pulse never overlaps a request, a rising error flag brings irq with it, and direction stays fixed during a transfer. Word-by-word addresses and data, the exact cycle of the done pulse and irq, the zero-count start and the abort point are left to the bench scenarios. So are the write-to-acknowledge semantics and the rejection of register writes while busy, since these depend on the programmed values and the full run of a transfer.

// File: rtl/dma_word_pkg.sv
package dma_word_pkg;
  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  // control/status bit positions
  localparam int BIT_ERR   = 0;
  localparam int BIT_IEN   = 1;
  localparam int BIT_START = 2;
  localparam int BIT_DIR   = 3;

  typedef struct packed {
    logic loadAddr;
    logic loadCount;
    logic advance;
  } dpStrobe_t;
endpackage

// File: rtl/dma_word_dp.sv
module dma_word_dp
  import dma_word_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] regWdata,
  output logic [ADDR_W-1:0] addrQ,
  output logic [CNT_W-1:0]  countQ,
  output logic              countZero,
  output logic              lastWord
);
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int ALIGN_W    = $clog2(WORD_BYTES);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      countQ <= '0;
    end else begin
      if (strobe.loadAddr)
        addrQ <= {regWdata[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
      else if (strobe.advance)
        addrQ <= addrQ + ADDR_W'(WORD_BYTES);

      if (strobe.loadCount)
        countQ <= regWdata[CNT_W-1:0];
      else if (strobe.advance)
        countQ <= countQ - CNT_W'(1);
    end
  end

  assign countZero = (countQ == '0);
  assign lastWord  = (countQ == CNT_W'(1));
endmodule

// File: rtl/dma_word_ctrl.sv
module dma_word_ctrl
  import dma_word_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              countZero,
  input  logic              lastWord,
  input  logic              fifoValid,
  input  logic              memReqReady,
  input  logic              memRespErr,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic              dir,
  output logic              intEn,
  output logic              errFlag,
  output logic              irq,
  output logic              donePulse,
  output logic              memReqValid,
  output logic              accept
);
  logic ctrlWr;
  logic launch;
  logic goodAcc;
  logic badAcc;

  assign ctrlWr      = regWe && (regSel == SEL_CTRL);
  assign launch      = ctrlWr && !busy && regWdata[BIT_START];
  assign memReqValid = busy && (dir ? fifoValid : 1'b1);
  assign accept      = memReqValid && memReqReady;
  assign goodAcc     = accept && !memRespErr;
  assign badAcc      = accept && memRespErr;

  always_comb begin
    strobe           = '0;
    strobe.loadAddr  = regWe && (regSel == SEL_ADDR)  && !busy;
    strobe.loadCount = regWe && (regSel == SEL_COUNT) && !busy;
    strobe.advance   = goodAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      dir       <= 1'b0;
      intEn     <= 1'b0;
      errFlag   <= 1'b0;
      irq       <= 1'b0;
      donePulse <= 1'b0;
    end else begin
      donePulse <= 1'b0;
      if (ctrlWr) irq <= 1'b0;
      if (ctrlWr && !busy) begin
        intEn <= regWdata[BIT_IEN];
        dir   <= regWdata[BIT_DIR];
        if (regWdata[BIT_ERR]) errFlag <= 1'b0;
      end
      if (launch) begin
        if (countZero) begin
          donePulse <= 1'b1;
          irq       <= regWdata[BIT_IEN];
        end else begin
          busy <= 1'b1;
        end
      end
      if (badAcc) begin
        busy    <= 1'b0;
        errFlag <= 1'b1;
        irq     <= 1'b1;
      end else if (goodAcc && lastWord) begin
        busy      <= 1'b0;
        donePulse <= 1'b1;
        if (intEn) irq <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_word_channel.sv
module dma_word_channel
  import dma_word_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 21
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              fifoValid,
  input  logic [DATA_W-1:0] fifoData,
  output logic              fifoPop,
  output logic              devOutValid,
  output logic [DATA_W-1:0] devOutData,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  input  logic              memReqReady,
  input  logic              memRespErr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              irq,
  output logic              donePulse
);
  dpStrobe_t         strobe;
  logic              busy, dir, intEn, errFlag, accept;
  logic              countZero, lastWord;
  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  countQ;

  dma_word_ctrl #(.DATA_W(DATA_W)) ctrlU (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .countZero(countZero), .lastWord(lastWord),
    .fifoValid(fifoValid), .memReqReady(memReqReady),
    .memRespErr(memRespErr), .strobe(strobe), .busy(busy), .dir(dir),
    .intEn(intEn), .errFlag(errFlag), .irq(irq), .donePulse(donePulse),
    .memReqValid(memReqValid), .accept(accept)
  );

  dma_word_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dpU (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWdata(regWdata),
    .addrQ(addrQ), .countQ(countQ), .countZero(countZero),
    .lastWord(lastWord)
  );

  assign memReqWrite = dir;
  assign memReqAddr  = addrQ;
  assign memReqData  = fifoData;
  assign fifoPop     = accept && dir && !memRespErr;
  assign devOutValid = accept && !dir && !memRespErr;
  assign devOutData  = memRdata;

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_ADDR:  regRdata = DATA_W'(addrQ);
      SEL_COUNT: regRdata = DATA_W'(countQ);
      SEL_CTRL: begin
        regRdata[BIT_ERR]   = errFlag;
        regRdata[BIT_IEN]   = intEn;
        regRdata[BIT_START] = busy;
        regRdata[BIT_DIR]   = dir;
      end
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_word_channel_chk.sv
module dma_word_channel_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              dir,
  input logic              errFlag,
  input logic              irq,
  input logic              donePulse,
  input logic              fifoPop,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr
);
  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

  a_r8_idle_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid);

  a_r4_pop_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> (memReqValid && memReqReady && memReqWrite));

  a_r12_read_no_pop: assert property (@(posedge clk) disable iff (!rstN)
    !memReqWrite |-> !fifoPop);

  a_r9_err_raises_irq: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> irq);

  a_r6_done_no_req: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !memReqValid);

  a_r2_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> (memReqAddr[1:0] == 2'b00));

  a_r11_dir_fixed: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(dir));
endmodule

bind dma_word_channel dma_word_channel_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .busy(busy), .dir(dir), .errFlag(errFlag),
  .irq(irq), .donePulse(donePulse), .fifoPop(fifoPop),
  .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqWrite(memReqWrite), .memReqAddr(memReqAddr)
);

// File: tb/dma_word_channel_test.sv
module dma_word_channel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        fifoValid = 1'b0;
  logic [31:0] fifoData = '0;
  logic        fifoPop, devOutValid, memReqValid, memReqWrite;
  logic [31:0] devOutData, memReqAddr, memReqData;
  logic        memReqReady = 1'b0;
  logic        memRespErr = 1'b0;
  logic [31:0] memRdata = '0;
  logic        irq, donePulse;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  dma_word_channel uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .fifoValid(fifoValid),
    .fifoData(fifoData), .fifoPop(fifoPop), .devOutValid(devOutValid),
    .devOutData(devOutData), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqData(memReqData), .memReqReady(memReqReady),
    .memRespErr(memRespErr), .memRdata(memRdata), .irq(irq),
    .donePulse(donePulse)
  );

  typedef struct packed {
    logic        dir;
    logic        ie;
    logic [15:0] base;
    logic [7:0]  len;
    logic [3:0]  rdy;
    logic [3:0]  fv;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b1, 16'h1000, 8'd4, 4'hF, 4'hF},
    '{1'b1, 1'b0, 16'h2006, 8'd5, 4'b0101, 4'hF},
    '{1'b1, 1'b1, 16'h3000, 8'd6, 4'hF, 4'b0110},
    '{1'b0, 1'b1, 16'h4000, 8'd3, 4'b1011, 4'hF},
    '{1'b0, 1'b0, 16'h5000, 8'd1, 4'hF, 4'hF},
    '{1'b1, 1'b1, 16'h6000, 8'd7, 4'b1101, 4'b1011}
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = val;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [31:0] val);
    regSel = sel;
    #1;
    val = regRdata;
  endtask

  task automatic runVec(input vec_t v);
    logic [31:0] base, rd;
    int idx, ie;
    bit sawReq, wordOk;
    base = {16'h0, v.base[15:2], 2'b00};
    writeReg(2'd0, {16'h0, v.base});
    writeReg(2'd1, {24'h0, v.len});
    writeReg(2'd2, {28'h0, v.dir, 1'b1, v.ie, 1'b0});
    idx = 0;
    wordOk = 1'b1;
    sawReq = 1'b0;
    ie = v.ie;
    for (int cyc = 0; cyc < 200 && idx < v.len; cyc++) begin
      memReqReady = v.rdy[cyc % 4];
      fifoValid   = v.fv[cyc % 4];
      fifoData    = 32'hC0DE_0000 + idx;
      memRdata    = 32'h5A5A_0000 ^ (base + 4 * idx);
      #1;
      if (memReqValid) sawReq = 1'b1;
      if (v.dir && !fifoValid && memReqValid) wordOk = 1'b0;
      if (memReqValid && memReqReady) begin
        if (memReqAddr != base + 4 * idx) wordOk = 1'b0;
        if (memReqWrite != v.dir) wordOk = 1'b0;
        if (v.dir && (memReqData != fifoData || !fifoPop || devOutValid))
          wordOk = 1'b0;
        if (!v.dir && (devOutData != memRdata || !devOutValid || fifoPop))
          wordOk = 1'b0;
        if (idx == v.len - 1 && donePulse) wordOk = 1'b0;
        idx++;
      end
      @(negedge clk);
    end
    memReqReady = 1'b0;
    fifoValid = 1'b0;
    #1;
    check(idx == v.len, "R4 word count", idx, v.len);
    check(wordOk && sawReq, v.dir ? "R5 write addresses/data" : "R12 read path",
          {31'h0, wordOk}, 32'h1);
    check(donePulse == 1'b1, "R6 done pulse", donePulse, 1);
    check(irq == v.ie, ie ? "R6 irq on completion" : "R7 no irq when disabled",
          irq, ie);
    readReg(2'd2, rd);
    check(rd[2] == 1'b0, "R6 start bit cleared", rd, {rd[31:3], 1'b0, rd[1:0]});
    readReg(2'd0, rd);
    check(rd == base + 4 * v.len, "R2 address advanced", rd, base + 4 * v.len);
    @(negedge clk);
    #1;
    check(donePulse == 1'b0, "R6 done single cycle", donePulse, 0);
    writeReg(2'd2, 32'h0000_000B);
    #1;
    check(irq == 1'b0, "R10 acknowledge clears irq", irq, 0);
  endtask

  initial begin
    logic [31:0] rd;
    int reqs;
    #1;
    repeat (3) @(negedge clk);
    #1;
    check(!memReqValid && !fifoPop && !irq && !donePulse, "R1 outputs in reset",
          {memReqValid, fifoPop, irq, donePulse}, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int s = 0; s < 3; s++) begin
      readReg(2'(s), rd);
      check(rd == 0, "R1 register reset value", rd, 0);
    end

    writeReg(2'd0, 32'h0000_1237);
    readReg(2'd0, rd);
    check(rd == 32'h0000_1234, "R2 address alignment", rd, 32'h1234);
    writeReg(2'd1, 32'hFFE0_0005);
    readReg(2'd1, rd);
    check(rd == 32'h5, "R3 count upper bits ignored", rd, 5);

    for (int k = 0; k < 6; k++) runVec(VECS[k]);

    // R8: zero count completes at once
    writeReg(2'd1, 32'h0);
    memReqReady = 1'b1;
    @(negedge clk);
    regWe = 1'b1; regSel = 2'd2; regWdata = 32'h6;
    @(negedge clk);
    regWe = 1'b0;
    #1;
    check(donePulse && irq, "R8 zero count immediate done",
          {donePulse, irq}, 2'b11);
    reqs = 0;
    for (int c = 0; c < 4; c++) begin
      #1; if (memReqValid) reqs++;
      @(negedge clk);
    end
    check(reqs == 0, "R8 zero count no requests", reqs, 0);
    memReqReady = 1'b0;

    // R10: ack starts nothing
    writeReg(2'd2, 32'h0000_000B);
    readReg(2'd2, rd);
    check(rd[2] == 1'b0 && !irq, "R10 ack leaves start clear", rd, 32'hA);

    // R9: error aborts
    writeReg(2'd0, 32'h7000);
    writeReg(2'd1, 32'd4);
    writeReg(2'd2, 32'h8 | 32'h4);
    fifoValid = 1'b1;
    memReqReady = 1'b1;
    @(negedge clk);
    memRespErr = 1'b1;
    @(negedge clk);
    memRespErr = 1'b0;
    memReqReady = 1'b0;
    #1;
    check(irq == 1'b1, "R9 error raises irq without enable", irq, 1);
    check(donePulse == 1'b0, "R9 no done on abort", donePulse, 0);
    readReg(2'd2, rd);
    check(rd[0] == 1'b1 && rd[2] == 1'b0, "R9 error set and stopped", rd, 32'h9);
    readReg(2'd1, rd);
    check(rd == 32'd3, "R9 count stops at aborted word", rd, 3);
    check(!memReqValid, "R9 no request after abort", memReqValid, 0);
    writeReg(2'd2, 32'h1);
    readReg(2'd2, rd);
    check(rd[0] == 1'b0 && !irq, "R10 error cleared by write 1", rd, 0);

    // R11: writes while busy ignored
    writeReg(2'd0, 32'h8000);
    writeReg(2'd1, 32'd5);
    writeReg(2'd2, 32'hC);
    fifoValid = 1'b1;
    writeReg(2'd2, 32'h4);
    writeReg(2'd1, 32'd9);
    writeReg(2'd0, 32'h0);
    readReg(2'd1, rd);
    check(rd == 32'd5, "R11 count unchanged while busy", rd, 5);
    readReg(2'd0, rd);
    check(rd == 32'h8000, "R11 address unchanged while busy", rd, 32'h8000);
    readReg(2'd2, rd);
    check(rd[3:2] == 2'b11, "R11 direction and busy kept", rd, 32'hC);
    memReqReady = 1'b1;
    reqs = 0;
    for (int c = 0; c < 20 && !donePulse; c++) begin
      #1; if (memReqValid && memReqReady) reqs++;
      @(negedge clk);
    end
    #1;
    check(reqs == 5 && donePulse, "R11 transfer finished unaltered", reqs, 5);
    memReqReady = 1'b0;
    fifoValid = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule